// File: doc/BRIEF.md
# Sequence-Indexed Transfer Controller

This block is a small transfer engine driven by a serial receiver. Each time the receiver finishes a byte, it pulses a request. On every request the engine first stores the byte at a fixed RAM word. When no sequence is open, the engine uses the byte as an index into a table of entries. Each entry either aborts to the CPU or points at the first of a chain of transfer descriptors.

A descriptor is two words. Word 0 holds the destination address in bits 31:16 and the source address in bits 15:0. Word 1 holds the flags in bits 31:16 and the 16-bit count in bits 15:0. Running a descriptor copies one word from source to destination. It then writes the descriptor back with both addresses incremented and the count decremented. Descriptors of one chain sit at consecutive two-word slots.

A chain-continue flag makes the next descriptor run within the same request. Without that flag, the chain waits and the next request resumes it. The end-of-sequence flag closes the chain. A single-cycle interrupt with a two-bit cause code reports three events: an abort, a count completion, or a transfer that asked to be reported.

Top module: `seq_xfer_ctrl`

## Requirements
- R1: After reset, irq is 0, irq_code is 0, en_q is 0, and neither mem_re nor mem_we is asserted.
- R2: A serviced request writes the received byte, zero-extended, to word BYTE_ADDR before any other memory access. mem_re and mem_we are never high together.
- R3: With no sequence open, the engine reads the entry at IDX_BASE + byte. For an entry with bit 31 clear, bits AW-1:0 give the address of the first descriptor.
- R4: An entry with bit 31 set causes no descriptor read. It clears en_q and raises irq with code 1. No sequence is opened.
- R5: A request seen while en_q is 0 is discarded: no memory write and no interrupt, even after en_q is later set.
- R6: A descriptor run copies the word at src to dst. It then writes word 0 as {dst+1, src+1} and word 1 as {flags, count-1}.
- R7: Flag bit 2 (chain-continue) with bit 0 clear runs the descriptor at ptr+2 in the same request. With bit 2 clear and bit 0 clear, the sequence stays open. The next request then stores its byte and runs the descriptor at ptr+2 without an index lookup.
- R8: Flag bit 0 (end-of-sequence) closes the sequence after that descriptor's transfer. The next request performs a fresh index lookup.
- R9: A transfer made with count equal to 1 raises irq with code 2.
- R10: A transfer whose flag bit 1 (report-every-transfer) is set raises irq with code 3, unless R9 applies, in which case code 2 is given.
- R11: irq is high for exactly one cycle per event. irq_code is 0 whenever irq is low.
- R12: A request arriving while the engine is busy is held and serviced on return to idle. Several such requests collapse into one, which keeps the last byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trig | input | 1 | One-cycle byte-received request |
| rx_byte | input | BW | Received byte, valid with trig |
| en_set | input | 1 | Software set of the trigger enable |
| en_clr | input | 1 | Software clear of the trigger enable |
| en_q | output | 1 | Current trigger enable |
| mem_re | output | 1 | Memory read strobe, data returns next cycle |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | AW | Word address |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, one cycle after mem_re |
| irq | output | 1 | Interrupt pulse to the CPU |
| irq_code | output | 2 | Cause: 1 abort, 2 count done, 3 per transfer |

## Verification
A wrong engine state shows up in RAM contents and on the interrupt pins within one request, which is at most about eleven cycles per descriptor. A lost sequence pointer makes the next request do an index lookup. That lookup raises an abort interrupt or leaves the expected destination word unwritten. A stale enable or pending flag shows up as a byte store that should or should not have happened. A wrong count or flag decode changes the written-back descriptor word or the cause code of the next interrupt.

// File: rtl/seqx_pkg.sv
package seqx_pkg;
  localparam int DW = 32;
  localparam int HW = 16;
  localparam int ABORT_BIT = 31;

  typedef enum logic [2:0] {
    S_IDLE, S_RD_IDX, S_RD_DESC, S_XFER, S_WB, S_IRQ
  } seqx_state_e;

  typedef enum logic [1:0] {
    IRQ_NONE = 2'd0, IRQ_ABORT = 2'd1, IRQ_CNT_DONE = 2'd2, IRQ_EACH = 2'd3
  } seqx_irq_e;

  typedef struct packed {
    logic [12:0] rsvd;
    logic        chain;
    logic        each;
    logic        eos;
  } seqx_flags_t;

  function automatic logic [HW-1:0] f_cnt_next(input logic [HW-1:0] c);
    return c - HW'(1);
  endfunction

  function automatic seqx_irq_e f_irq_pick(input logic [HW-1:0] c, input logic each);
    if (c == HW'(1)) return IRQ_CNT_DONE;
    else if (each)   return IRQ_EACH;
    else             return IRQ_NONE;
  endfunction
endpackage

// File: rtl/seqx_trig_gate.sv
module seqx_trig_gate #(
  parameter int BW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          trig,
  input  logic [BW-1:0] rx_byte,
  input  logic          take,
  input  logic          en_set,
  input  logic          en_clr,
  input  logic          hw_clr,
  output logic          pend,
  output logic [BW-1:0] pend_byte,
  output logic          en_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend      <= 1'b0;
      pend_byte <= '0;
      en_q      <= 1'b0;
    end else begin
      if (trig) begin
        pend      <= 1'b1;
        pend_byte <= rx_byte;
      end else if (take) begin
        pend <= 1'b0;
      end
      if (hw_clr || en_clr) en_q <= 1'b0;
      else if (en_set)      en_q <= 1'b1;
    end
  end
endmodule

// File: rtl/seqx_irq_pick.sv
module seqx_irq_pick
  import seqx_pkg::*;
(
  input  logic [HW-1:0] cnt,
  input  logic          each,
  output seqx_irq_e     code,
  output logic          need
);
  always_comb begin
    code = f_irq_pick(cnt, each);
    need = (code != IRQ_NONE);
  end
endmodule

// File: rtl/seq_xfer_ctrl.sv
module seq_xfer_ctrl
  import seqx_pkg::*;
#(
  parameter int            AW        = 16,
  parameter int            BW        = 8,
  parameter logic [AW-1:0] IDX_BASE  = AW'('h100),
  parameter logic [AW-1:0] BYTE_ADDR = AW'('h080)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          trig,
  input  logic [BW-1:0] rx_byte,
  input  logic          en_set,
  input  logic          en_clr,
  output logic          en_q,
  output logic          mem_re,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  output logic          irq,
  output logic [1:0]    irq_code
);
  localparam logic [AW-1:0] STEP = AW'(2);

  seqx_state_e   st;
  logic [1:0]    ph;
  logic [AW-1:0] ptr, src, dst;
  logic [HW-1:0] cnt;
  seqx_flags_t   flg;
  logic [BW-1:0] byte_q;
  logic          seq_on, ret_desc;
  seqx_irq_e     code_q;

  // named events
  logic          pend, accept, drop, hw_abort, wb_done, cont;
  logic [BW-1:0] pend_byte;
  seqx_irq_e     pick_code;
  logic          pick_need;

  assign accept   = (st == S_IDLE) && pend && en_q;
  assign drop     = (st == S_IDLE) && pend && !en_q;
  assign hw_abort = (st == S_RD_IDX) && (ph == 2'd1) && mem_rdata[ABORT_BIT];
  assign wb_done  = (st == S_WB) && (ph == 2'd1);
  assign cont     = !flg.eos && flg.chain;

  seqx_trig_gate #(.BW(BW)) u_gate (
    .clk(clk), .rst_n(rst_n), .trig(trig), .rx_byte(rx_byte),
    .take(accept || drop), .en_set(en_set), .en_clr(en_clr),
    .hw_clr(hw_abort), .pend(pend), .pend_byte(pend_byte), .en_q(en_q)
  );

  seqx_irq_pick u_pick (
    .cnt(cnt), .each(flg.each), .code(pick_code), .need(pick_need)
  );

  always_comb begin
    mem_re    = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = '0;
    mem_wdata = '0;
    case (st)
      S_IDLE: if (accept) begin
        mem_we    = 1'b1;
        mem_addr  = BYTE_ADDR;
        mem_wdata = DW'(pend_byte);
      end
      S_RD_IDX: if (ph == 2'd0) begin
        mem_re   = 1'b1;
        mem_addr = IDX_BASE + AW'(byte_q);
      end
      S_RD_DESC: begin
        if (ph == 2'd0) begin
          mem_re   = 1'b1;
          mem_addr = ptr;
        end else if (ph == 2'd1) begin
          mem_re   = 1'b1;
          mem_addr = ptr + AW'(1);
        end
      end
      S_XFER: begin
        if (ph == 2'd0) begin
          mem_re   = 1'b1;
          mem_addr = src;
        end else begin
          mem_we    = 1'b1;
          mem_addr  = dst;
          mem_wdata = mem_rdata;
        end
      end
      S_WB: begin
        mem_we = 1'b1;
        if (ph == 2'd0) begin
          mem_addr  = ptr;
          mem_wdata = {HW'(dst + AW'(1)), HW'(src + AW'(1))};
        end else begin
          mem_addr  = ptr + AW'(1);
          mem_wdata = {flg, f_cnt_next(cnt)};
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      ph       <= 2'd0;
      ptr      <= '0;
      src      <= '0;
      dst      <= '0;
      cnt      <= '0;
      flg      <= '0;
      byte_q   <= '0;
      seq_on   <= 1'b0;
      ret_desc <= 1'b0;
      code_q   <= IRQ_NONE;
    end else begin
      case (st)
        S_IDLE: begin
          ph <= 2'd0;
          if (accept) begin
            byte_q <= pend_byte;
            st     <= seq_on ? S_RD_DESC : S_RD_IDX;
          end
        end
        S_RD_IDX: begin
          if (ph == 2'd0) ph <= 2'd1;
          else begin
            ph <= 2'd0;
            if (mem_rdata[ABORT_BIT]) begin
              code_q   <= IRQ_ABORT;
              ret_desc <= 1'b0;
              st       <= S_IRQ;
            end else begin
              ptr <= mem_rdata[AW-1:0];
              st  <= S_RD_DESC;
            end
          end
        end
        S_RD_DESC: begin
          case (ph)
            2'd0: ph <= 2'd1;
            2'd1: begin
              src <= mem_rdata[AW-1:0];
              dst <= mem_rdata[HW+AW-1:HW];
              ph  <= 2'd2;
            end
            2'd2: begin
              flg <= mem_rdata[DW-1:HW];
              cnt <= mem_rdata[HW-1:0];
              ph  <= 2'd0;
              st  <= S_XFER;
            end
            default: begin
              ph <= 2'd0;
              st <= S_IDLE;
            end
          endcase
        end
        S_XFER: begin
          if (ph == 2'd0) ph <= 2'd1;
          else begin
            ph <= 2'd0;
            st <= S_WB;
          end
        end
        S_WB: begin
          if (!wb_done) ph <= 2'd1;
          else begin
            ph     <= 2'd0;
            seq_on <= !flg.eos;
            ptr    <= ptr + STEP;
            if (pick_need) begin
              code_q   <= pick_code;
              ret_desc <= cont;
              st       <= S_IRQ;
            end else begin
              st <= cont ? S_RD_DESC : S_IDLE;
            end
          end
        end
        S_IRQ: begin
          ph <= 2'd0;
          st <= ret_desc ? S_RD_DESC : S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign irq      = (st == S_IRQ);
  assign irq_code = irq ? 2'(code_q) : 2'b00;
endmodule

// File: rtl/seq_xfer_ctrl_chk.sv
module seq_xfer_ctrl_chk
  import seqx_pkg::*;
#(
  parameter int            AW        = 16,
  parameter int            BW        = 8,
  parameter logic [AW-1:0] BYTE_ADDR = AW'('h080)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          irq,
  input logic [1:0]    irq_code,
  input logic          en_q,
  input logic          mem_re,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr,
  input logic [DW-1:0] mem_wdata,
  input seqx_state_e   st,
  input logic          hw_abort,
  input logic          pend
);
  p_irq_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);
  p_code_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !irq |-> (irq_code == 2'd0));
  p_abort_disables_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && irq_code == 2'd1) |-> !en_q);
  p_abort_reports_r4: assert property (@(posedge clk) disable iff (!rst_n)
    hw_abort |=> (irq && irq_code == 2'd1));
  p_port_exclusive_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_re && mem_we));
  p_byte_store_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE && mem_we) |-> (mem_addr == BYTE_ADDR && mem_wdata[DW-1:BW] == '0));
  p_no_start_disabled_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE && !en_q) |=> (st == S_IDLE));
  p_pend_kept_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && st != S_IDLE) |=> pend);
endmodule

bind seq_xfer_ctrl seq_xfer_ctrl_chk #(.AW(AW), .BW(BW), .BYTE_ADDR(BYTE_ADDR)) u_chk (
  .clk(clk), .rst_n(rst_n), .irq(irq), .irq_code(irq_code), .en_q(en_q),
  .mem_re(mem_re), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
  .st(st), .hw_abort(hw_abort), .pend(pend)
);

// File: tb/seq_xfer_ctrl_bench.sv
module seq_xfer_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        trig = 1'b0;
  logic [7:0]  rx_byte = '0;
  logic        en_set = 1'b0, en_clr = 1'b0;
  logic        en_q, mem_re, mem_we, irq;
  logic [15:0] mem_addr;
  logic [31:0] mem_wdata, mem_rdata;
  logic [1:0]  irq_code;

  logic [31:0] mem [0:1023];
  int n_chk = 0, n_fail = 0, n_irq = 0, n_dread = 0, n_glitch = 0;
  logic [1:0] irq_log [0:31];
  logic prev_irq = 1'b0;
  bit   done = 1'b0;

  always #2 clk = ~clk;

  seq_xfer_ctrl u_seq_xfer_ctrl (
    .clk(clk), .rst_n(rst_n), .trig(trig), .rx_byte(rx_byte),
    .en_set(en_set), .en_clr(en_clr), .en_q(en_q),
    .mem_re(mem_re), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .irq(irq), .irq_code(irq_code)
  );

  always @(posedge clk) begin
    if (mem_we) mem[mem_addr[9:0]] <= mem_wdata;
    if (mem_re) mem_rdata <= mem[mem_addr[9:0]];
  end

  always @(negedge clk) begin
    if (rst_n) begin
      if (irq) begin
        if (n_irq < 32) irq_log[n_irq] = irq_code;
        n_irq++;
      end
      if (irq && prev_irq) n_glitch++;
      if (!irq && irq_code != 2'd0) n_glitch++;
      if (mem_re && mem_addr >= 16'h200 && mem_addr < 16'h300) n_dread++;
      prev_irq = irq;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic eq(input string tag, input logic [31:0] act, input logic [31:0] exp);
    chk(act === exp, tag, act, exp);
  endtask

  task automatic poke(input int a, input logic [31:0] d);
    @(negedge clk);
    mem[a] <= d;
  endtask

  task automatic fire(input logic [7:0] b);
    @(negedge clk);
    trig = 1'b1;
    rx_byte = b;
    @(negedge clk);
    trig = 1'b0;
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    @(negedge clk);
    eq("R1 irq", {31'b0, irq}, 32'd0);
    eq("R1 irq_code", {30'b0, irq_code}, 32'd0);
    eq("R1 en_q", {31'b0, en_q}, 32'd0);
    eq("R1 mem strobes", {30'b0, mem_re, mem_we}, 32'd0);
  endtask

  task automatic t_disabled;
    int i0;
    i0 = n_irq;
    poke('h080, 32'hDEAD_BEEF);
    poke('h105, 32'h0000_0200);
    fire(8'h05);
    settle(20);
    eq("R5 byte not stored", mem['h080], 32'hDEAD_BEEF);
    @(negedge clk); en_set = 1'b1;
    @(negedge clk); en_set = 1'b0;
    settle(20);
    eq("R5 dropped after enable", mem['h080], 32'hDEAD_BEEF);
    eq("R5 no irq", n_irq - i0, 32'd0);
    eq("R5 en_q set", {31'b0, en_q}, 32'd1);
  endtask

  task automatic t_single;
    int i0;
    i0 = n_irq;
    poke('h107, 32'h0000_0200);
    poke('h200, {16'h0340, 16'h0300});
    poke('h201, {16'h0003, 16'd3});
    poke('h300, 32'hCAFE_0001);
    fire(8'h07);
    settle(40);
    eq("R2 byte stored", mem['h080], 32'h0000_0007);
    eq("R3 R6 copy", mem['h340], 32'hCAFE_0001);
    eq("R6 wb word0", mem['h200], {16'h0341, 16'h0301});
    eq("R6 wb word1", mem['h201], {16'h0003, 16'd2});
    eq("R10 one irq", n_irq - i0, 32'd1);
    eq("R10 code each", {30'b0, irq_log[i0]}, 32'd3);
  endtask

  task automatic t_chain;
    int i0;
    i0 = n_irq;
    poke('h109, 32'h0000_0210);
    poke('h210, {16'h0350, 16'h0310});
    poke('h211, {16'h0006, 16'd1});
    poke('h212, {16'h0360, 16'h0320});
    poke('h213, {16'h0001, 16'd5});
    poke('h310, 32'h1111_0000);
    poke('h320, 32'h2222_0000);
    fire(8'h09);
    settle(60);
    eq("R7 first copy", mem['h350], 32'h1111_0000);
    eq("R7 chained copy", mem['h360], 32'h2222_0000);
    eq("R9 count to zero", mem['h211], {16'h0006, 16'd0});
    eq("R7 second wb", mem['h213], {16'h0001, 16'd4});
    eq("R9 one irq", n_irq - i0, 32'd1);
    eq("R9 R10 code done wins", {30'b0, irq_log[i0]}, 32'd2);
  endtask

  task automatic t_suspend;
    int i0, d0;
    i0 = n_irq;
    poke('h111, 32'h0000_0220);
    poke('h220, {16'h0370, 16'h0330});
    poke('h221, {16'h0000, 16'd4});
    poke('h222, {16'h0378, 16'h0338});
    poke('h223, {16'h0001, 16'd2});
    poke('h330, 32'h0000_3333);
    poke('h338, 32'h0000_4444);
    poke('h122, 32'h8000_0000);
    fire(8'h11);
    settle(40);
    eq("R7 first of suspended", mem['h370], 32'h0000_3333);
    eq("R7 next untouched", mem['h223], {16'h0001, 16'd2});
    fire(8'h22);
    settle(40);
    eq("R7 resumed copy", mem['h378], 32'h0000_4444);
    eq("R7 byte stored", mem['h080], 32'h0000_0022);
    eq("R7 no index abort", n_irq - i0, 32'd0);
    eq("R7 en kept", {31'b0, en_q}, 32'd1);
    d0 = n_dread;
    poke('h378, 32'h0);
    fire(8'h22);
    settle(40);
    eq("R8 fresh lookup aborts", n_irq - i0, 32'd1);
    eq("R4 abort code", {30'b0, irq_log[i0]}, 32'd1);
    eq("R4 en cleared", {31'b0, en_q}, 32'd0);
    eq("R4 no descriptor read", n_dread - d0, 32'd0);
    eq("R4 no copy", mem['h378], 32'h0);
    @(negedge clk); en_set = 1'b1;
    @(negedge clk); en_set = 1'b0;
  endtask

  task automatic t_pending;
    int i0;
    i0 = n_irq;
    poke('h130, 32'h0000_0230);
    poke('h230, {16'h03A0, 16'h0390});
    poke('h231, {16'h0003, 16'd10});
    poke('h390, 32'h0000_5555);
    poke('h391, 32'h0000_6666);
    fire(8'h30);
    settle(2);
    fire(8'h30);
    fire(8'h30);
    settle(80);
    eq("R12 second run copy", mem['h3A1], 32'h0000_6666);
    eq("R12 collapsed count", mem['h231], {16'h0003, 16'd8});
    eq("R12 two irqs", n_irq - i0, 32'd2);
    eq("R11 no glitch", n_glitch, 32'd0);
  endtask

  task automatic report;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    for (int i = 0; i < 1024; i++) mem[i] = 32'h0;
    mem_rdata = '0;
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    t_reset;
    t_disabled;
    t_single;
    t_chain;
    t_suspend;
    t_pending;
    done = 1'b1;
    report;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      report;
    end
  end
endmodule